// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block turns the status flags of an asynchronous serial port into four interrupt request lines: transmit data, receive data, receive data with error, and idle line. It holds a four-bit enable register with one bit per request. The register is written through a strobe, and both the hardware reset and a software reset command clear it. The flags themselves are produced elsewhere and arrive as level inputs. Each request line is a registered level. It stays high for as long as its condition holds.

The receive data request and the receive-with-error request never fire together. When the error enable is set and any of parity error, framing error or overrun is present, the error request takes over and the plain receive request is held off. The idle-line request comes from a private latch. It fires at most once per idle period, however long the line stays idle. An acknowledge from the interrupt controller drops the request and disarms the latch. Only the receiver's character-complete strobe arms it again. The raw idle flag is also passed through to an output untouched, so software always sees the true line state.

Top module: `sport_irq_gen`

## Requirements
- R1: One clock edge after the transmit enable (write field bit 0) and the transmit-empty flag are both seen high, `irq_tx` is high. If either is low, `irq_tx` is low.
- R2: One clock edge after the receive enable (field bit 1) and the receive-full flag are both seen high, `irq_rx` is high. The exception in R3 is the only case where this does not happen.
- R3: When the error enable (field bit 2) is set and any of `perr`, `ferr` or `ovrn` is high, `irq_rxerr` rises one edge later and `irq_rx` is held low. `irq_rx` and `irq_rxerr` are never high together.
- R4: `irq_idle` rises one edge after the idle enable (field bit 3) and `idle_flag` are both high while the latch is armed. The latch is armed out of reset. An idle flag seen while the enable is clear does not disarm the latch.
- R5: An `idle_ack` pulse forces `irq_idle` low on the following edge.
- R6: After an acknowledge, `irq_idle` stays low for as long as the line stays idle. It rises again only after a `char_done` pulse has re-armed the latch.
- R7: `idle_stat` equals `idle_flag` at all times, whatever the state of the idle latch.
- R8: A hardware reset (`rst_n` low) or a `soft_rst` pulse clears all four enable bits. Every request is low one edge after the enables clear.
- R9: Outputs are registered levels. A request that is not acknowledged stays high while its condition lasts, and falls one edge after the condition goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software reset command, clears enables |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable field: bit0 tx, bit1 rx, bit2 rx error, bit3 idle |
| tdre | input | 1 | Transmit data register empty |
| rdrf | input | 1 | Receive data register full |
| perr | input | 1 | Parity error |
| ferr | input | 1 | Framing error |
| ovrn | input | 1 | Overrun |
| idle_flag | input | 1 | Receive line idle status |
| char_done | input | 1 | Character received strobe |
| idle_ack | input | 1 | Idle request acknowledge |
| irq_tx | output | 1 | Transmit data request |
| irq_rx | output | 1 | Receive data request |
| irq_rxerr | output | 1 | Receive-with-error request |
| irq_idle | output | 1 | Idle-line request |
| idle_stat | output | 1 | Idle flag as seen by software |

## Verification
The bench covers each of the three error sources alone and all three together. A design with the wrong priority would raise both receive lines at once. A design that ignores the error enable would drop the plain receive request. The bench holds the line idle for several cycles after an acknowledge. A latch without the arming gate would fire again there. The bench also shows that an idle period seen while the idle enable is clear leaves the latch armed. Soft reset is checked with a transmit request active. An enable register that ignores that command would leave `irq_tx` high.

// File: rtl/sport_irq_gen.sv
module sport_irq_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       en_we,
  input  logic [3:0] en_wdata,
  input  logic       tdre,
  input  logic       rdrf,
  input  logic       perr,
  input  logic       ferr,
  input  logic       ovrn,
  input  logic       idle_flag,
  input  logic       char_done,
  input  logic       idle_ack,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_rxerr,
  output logic       irq_idle,
  output logic       idle_stat
);

  logic [3:0] en_q;
  logic       armed_q;
  logic       any_err;
  logic       err_hit;

  assign any_err   = perr | ferr | ovrn;
  assign err_hit   = en_q[2] & any_err;
  assign idle_stat = idle_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (soft_rst) en_q <= '0;
    else if (en_we)    en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b1;
    else if (char_done) armed_q <= 1'b1;
    else if (idle_ack)  armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx    <= 1'b0;
      irq_rx    <= 1'b0;
      irq_rxerr <= 1'b0;
      irq_idle  <= 1'b0;
    end else begin
      irq_tx    <= en_q[0] & tdre;
      irq_rx    <= en_q[1] & rdrf & ~err_hit;
      irq_rxerr <= err_hit;
      irq_idle  <= ~idle_ack & armed_q & en_q[3] & idle_flag;
    end
  end

endmodule

// File: rtl/sport_irq_gen_chk.sv
module sport_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       tdre,
  input logic       rdrf,
  input logic       perr,
  input logic       ferr,
  input logic       ovrn,
  input logic       idle_ack,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       irq_rxerr,
  input logic       irq_idle,
  input logic       armed_q,
  input logic [3:0] en_q
);

  // R1
  tx_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tdre));

  // R2
  rx_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rdrf));

  // R3
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_rxerr));

  // R3
  rxerr_needs_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rxerr) |-> $past(perr | ferr | ovrn));

  // R5
  ack_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |=> !irq_idle);

  // R6
  idle_rise_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_idle) |-> $past(armed_q));

  // R8
  soft_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en_q == 4'b0000));

endmodule

bind sport_irq_gen sport_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .tdre(tdre), .rdrf(rdrf), .perr(perr), .ferr(ferr), .ovrn(ovrn),
  .idle_ack(idle_ack), .irq_tx(irq_tx), .irq_rx(irq_rx),
  .irq_rxerr(irq_rxerr), .irq_idle(irq_idle),
  .armed_q(armed_q), .en_q(en_q)
);

// File: tb/sim_sport_irq_gen.sv
module sim_sport_irq_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, en_we = 1'b0;
  logic [3:0] en_wdata = '0;
  logic tdre = 0, rdrf = 0, perr = 0, ferr = 0, ovrn = 0;
  logic idle_flag = 0, char_done = 0, idle_ack = 0;
  logic irq_tx, irq_rx, irq_rxerr, irq_idle, idle_stat;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  sport_irq_gen u0 (.*);

  // [11:8] enables, [7] tdre, [6] rdrf, [5] perr, [4] ferr, [3] ovrn,
  // [2] expected tx, [1] expected rx, [0] expected rxerr
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_1_1_100_000, 12'b0001_1_0_000_100, 12'b0001_0_1_000_000,
    12'b0010_0_1_000_010, 12'b0010_1_1_000_010, 12'b0110_0_1_100_001,
    12'b0110_0_1_010_001, 12'b0110_0_1_001_001, 12'b0010_0_1_100_010,
    12'b0100_0_0_010_001, 12'b0111_1_1_000_110, 12'b1111_1_0_001_101,
    12'b0011_1_1_111_110
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_en(input logic [3:0] v);
    en_we = 1'b1; en_wdata = v;
    ticks(1);
    en_we = 1'b0;
  endtask

  initial begin
    tdre = 1; rdrf = 1; perr = 1; idle_flag = 1;
    ticks(3);
    chk("R8 reset tx", irq_tx, 0);
    chk("R8 reset rx", irq_rx, 0);
    chk("R8 reset rxerr", irq_rxerr, 0);
    chk("R8 reset idle", irq_idle, 0);
    rst_n = 1'b1;
    ticks(2);
    chk("R8 enables clear after reset", irq_tx | irq_rx | irq_rxerr | irq_idle, 0);
    // R4: an idle period with the enable clear does not disarm the latch
    chk("R7 idle_stat follows high", idle_stat, 1);
    idle_flag = 0; perr = 0;
    #1 chk("R7 idle_stat follows low", idle_stat, 0);

    for (int k = 0; k < NV; k++) begin
      tdre = VEC[k][7]; rdrf = VEC[k][6];
      perr = VEC[k][5]; ferr = VEC[k][4]; ovrn = VEC[k][3];
      wr_en(VEC[k][11:8]);
      ticks(1);
      chk($sformatf("R1 vec%0d tx", k), irq_tx, VEC[k][2]);
      chk($sformatf("R2 vec%0d rx", k), irq_rx, VEC[k][1]);
      chk($sformatf("R3 vec%0d rxerr", k), irq_rxerr, VEC[k][0]);
    end

    // R9: level holds, then falls one edge after the condition goes away
    tdre = 1; perr = 0; ferr = 0; ovrn = 0; rdrf = 0;
    wr_en(4'b0001);
    ticks(4);
    chk("R9 tx held", irq_tx, 1);
    tdre = 0;
    ticks(1);
    chk("R9 tx falls", irq_tx, 0);

    // R8: soft reset clears enables
    tdre = 1;
    ticks(1);
    chk("R8 tx before soft reset", irq_tx, 1);
    soft_rst = 1; ticks(1); soft_rst = 0;
    ticks(1);
    chk("R8 tx after soft reset", irq_tx, 0);
    tdre = 0;

    // R4..R6: idle latch
    idle_flag = 1;
    wr_en(4'b1000);
    ticks(1);
    chk("R4 idle fires, latch still armed", irq_idle, 1);
    ticks(3);
    chk("R9 idle held", irq_idle, 1);
    chk("R7 idle_stat while latched", idle_stat, 1);
    idle_ack = 1; ticks(1); idle_ack = 0;
    chk("R5 ack clears", irq_idle, 0);
    ticks(6);
    chk("R6 no refire while idle", irq_idle, 0);
    chk("R7 idle_stat after ack", idle_stat, 1);
    char_done = 1; ticks(1); char_done = 0;
    ticks(1);
    chk("R6 refire after char_done", irq_idle, 1);
    idle_flag = 0;
    ticks(1);
    chk("R9 idle falls with flag", irq_idle, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule